// File: doc/BRIEF.md
# Host command byte decoder

This block sits behind a serial receiver in a logic-analyzer front end and turns the stream of received bytes into control actions. Each strobed byte is classified by its top bit. A byte with bit 7 clear is a one-byte command. It is carried out at once as a single-cycle pulse (reset, arm, identify, XON or XOFF), and any other value of that kind is dropped. A byte with bit 7 set opens a five-byte command: that opcode plus four payload bytes. The payload bytes are gathered least-significant first into a 32-bit word, and a single write strobe then presents the word with the opcode and a decoded register selector and trigger stage.

The parser has two states. IDLE classifies each byte. PAYLOAD gathers the four data bytes. Three transitions exist. *Long opcode* goes from IDLE to PAYLOAD when a byte with bit 7 set arrives. *Fourth byte* goes from PAYLOAD to IDLE on the last payload byte and emits the write. *Stall timeout* goes from PAYLOAD to IDLE, with no write, when `GAP_CYCLES` cycles pass without a byte. Because a byte of 00h sent while the parser still expects payload is taken as data, the host recovers a lost parser either by waiting for the stall timeout or by sending 00h five times in a row. The identify pulse asks the transmit side to send the constant four-byte reply word that this block also drives.

Top module: `hostcmd_decoder`

## Requirements
- R1: While and straight after reset, every pulse output and `wr_en` are low and the parser is in IDLE.
- R2: In IDLE, bytes 00h, 01h, 02h, 11h and 13h raise `cmd_reset`, `cmd_arm`, `cmd_ident`, `cmd_xon` and `cmd_xoff` respectively. The pulse lasts exactly one cycle and is high in the cycle after the byte's strobe edge.
- R3: In IDLE, a byte with bit 7 clear that is not one of those five codes produces no pulse and no write.
- R4: A byte with bit 7 set moves the parser to PAYLOAD, and the next four strobed bytes are taken as data, whatever their values. None of them raises a pulse.
- R5: The payload word is assembled with the first payload byte in bits 7:0 and the fourth in bits 31:24. `wr_en` is high for one cycle, the cycle after the fourth byte's edge, with `wr_data` and `wr_opcode` valid.
- R6: For opcodes of the form 1100ssyy with yy ≠ 11, `wr_stage` equals ss. `wr_sel` equals yy: 0 selects the trigger mask, 1 the trigger value and 2 the trigger configuration.
- R7: Opcode 80h writes with `wr_sel` = 3 (rate divider), 81h with 4 (read/delay counts) and 82h with 5 (flags). `wr_stage` is 0 in all three cases.
- R8: Any other byte with bit 7 set, including 1100ss11, still consumes four payload bytes but produces no write. The following byte is parsed as a new command.
- R9: If `GAP_CYCLES` consecutive cycles pass in PAYLOAD without a strobe, the partial command is dropped with no write, and the next byte is parsed as a new command.
- R10: Five consecutive 00h bytes sent from any parser position (IDLE, or 1 to 4 payload bytes pending) leave the parser in IDLE. With p bytes pending they give 5−p reset pulses.
- R11: `id_reply` holds the reply word, sent lowest byte first: 'S' (53h), 'L' (4Ch), 'A' (41h), then the version character `PROTO_VER` (default '1', 31h).
- R12: At most one of the five pulses and `wr_en` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_byte | input | 8 | Received byte |
| rx_valid | input | 1 | One-cycle strobe marking `rx_byte` valid |
| cmd_reset | output | 1 | Reset command pulse |
| cmd_arm | output | 1 | Arm-trigger pulse |
| cmd_ident | output | 1 | Request to send the identification reply |
| cmd_xon | output | 1 | Resume-transmission pulse |
| cmd_xoff | output | 1 | Pause-transmission pulse |
| id_reply | output | 32 | Identification reply, byte 0 sent first |
| wr_en | output | 1 | Register write strobe |
| wr_opcode | output | 8 | Opcode of the command being written |
| wr_sel | output | 3 | Target register: 0 mask, 1 value, 2 config, 3 divider, 4 counts, 5 flags |
| wr_stage | output | 2 | Trigger stage for trigger writes, 0 otherwise |
| wr_data | output | 32 | Assembled payload word |

## Verification
A short-command pulse is registered on the edge that samples its byte, so it is visible for exactly the following cycle. A write strobe appears the same way, one cycle after the fourth payload byte's edge. A stall timeout fires on the `GAP_CYCLES`-th strobe-free cycle in PAYLOAD, so the bench waits either a few cycles short of that limit or a few cycles past it, never at the boundary. The bench drives bytes on falling edges and records every output pulse 1 ns after each rising edge. It compares the recorded counts and the last write's fields only after one further idle falling edge, by which time every result of the stimulus has settled.

// File: rtl/hostcmd_pkg.sv
package hostcmd_pkg;

    localparam logic [7:0] OP_RESET = 8'h00;
    localparam logic [7:0] OP_ARM   = 8'h01;
    localparam logic [7:0] OP_IDENT = 8'h02;
    localparam logic [7:0] OP_XON   = 8'h11;
    localparam logic [7:0] OP_XOFF  = 8'h13;
    localparam logic [7:0] OP_DIV   = 8'h80;
    localparam logic [7:0] OP_CNT   = 8'h81;
    localparam logic [7:0] OP_FLAGS = 8'h82;

    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_PAYLOAD = 1'b1
    } state_e;

    typedef enum logic [2:0] {
        ACT_NONE  = 3'd0,
        ACT_RESET = 3'd1,
        ACT_ARM   = 3'd2,
        ACT_IDENT = 3'd3,
        ACT_XON   = 3'd4,
        ACT_XOFF  = 3'd5
    } short_act_e;

    typedef enum logic [2:0] {
        SEL_TRIG_MASK  = 3'd0,
        SEL_TRIG_VALUE = 3'd1,
        SEL_TRIG_CFG   = 3'd2,
        SEL_DIVIDER    = 3'd3,
        SEL_COUNTS     = 3'd4,
        SEL_FLAGS      = 3'd5,
        SEL_NONE       = 3'd7
    } sel_e;

    typedef struct packed {
        logic       is_long;
        short_act_e act;
        sel_e       sel;
        logic [1:0] stage;
    } byte_class_t;

endpackage

// File: rtl/hostcmd_classify.sv
module hostcmd_classify
    import hostcmd_pkg::*;
(
    input  logic [7:0]  byte_in,
    output byte_class_t cls
);
    always_comb begin
        cls.is_long = byte_in[7];
        cls.act     = ACT_NONE;
        cls.sel     = SEL_NONE;
        cls.stage   = 2'd0;
        if (!byte_in[7]) begin
            case (byte_in)
                OP_RESET: cls.act = ACT_RESET;
                OP_ARM:   cls.act = ACT_ARM;
                OP_IDENT: cls.act = ACT_IDENT;
                OP_XON:   cls.act = ACT_XON;
                OP_XOFF:  cls.act = ACT_XOFF;
                default:  cls.act = ACT_NONE;
            endcase
        end else if (byte_in[7:4] == 4'hC) begin
            if (byte_in[1:0] != 2'b11) begin
                cls.sel   = sel_e'({1'b0, byte_in[1:0]});
                cls.stage = byte_in[3:2];
            end
        end else begin
            case (byte_in)
                OP_DIV:   cls.sel = SEL_DIVIDER;
                OP_CNT:   cls.sel = SEL_COUNTS;
                OP_FLAGS: cls.sel = SEL_FLAGS;
                default:  cls.sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/hostcmd_payload.sv
module hostcmd_payload #(
    parameter int DATA_BYTES = 4,
    parameter int BYTE_W     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic                         shift,
    input  logic [BYTE_W-1:0]            byte_in,
    output logic [DATA_BYTES*BYTE_W-1:0] word,
    output logic                         last
);
    localparam int WORD_W = DATA_BYTES * BYTE_W;
    localparam int CNT_W  = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_BYTES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= '0;
        end else if (shift) begin
            cnt_q <= (cnt_q == LAST_IDX) ? '0 : cnt_q + 1'b1;
        end
    end

    generate
        if (DATA_BYTES > 1) begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    word <= '0;
                end else if (shift) begin
                    word <= {byte_in, word[WORD_W-1:BYTE_W]};
                end
            end
        end else begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    word <= '0;
                end else if (shift) begin
                    word <= byte_in;
                end
            end
        end
    endgenerate

    assign last = (cnt_q == LAST_IDX);
endmodule

// File: rtl/hostcmd_gap_timer.sv
module hostcmd_gap_timer #(
    parameter int LIMIT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic kick,
    output logic expire
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] END_VAL = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || kick || expire) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire = run && !kick && (cnt_q == END_VAL);
endmodule

// File: rtl/hostcmd_decoder.sv
module hostcmd_decoder
    import hostcmd_pkg::*;
#(
    parameter int         DATA_BYTES = 4,
    parameter int         GAP_CYCLES = 4096,
    parameter logic [7:0] PROTO_VER  = 8'h31
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [7:0]              rx_byte,
    input  logic                    rx_valid,
    output logic                    cmd_reset,
    output logic                    cmd_arm,
    output logic                    cmd_ident,
    output logic                    cmd_xon,
    output logic                    cmd_xoff,
    output logic [31:0]             id_reply,
    output logic                    wr_en,
    output logic [7:0]              wr_opcode,
    output logic [2:0]              wr_sel,
    output logic [1:0]              wr_stage,
    output logic [DATA_BYTES*8-1:0] wr_data
);
    localparam logic [31:0] ID_WORD = {PROTO_VER, 8'h41, 8'h4C, 8'h53};

    state_e      state_q, state_d;
    byte_class_t cls;
    logic        pl_last;
    logic        gap_expire;
    logic        take_long;
    logic        take_payload;
    sel_e        sel_q;
    logic [1:0]  stage_q;
    logic [7:0]  op_q;

    hostcmd_classify u_classify (
        .byte_in (rx_byte),
        .cls     (cls)
    );

    assign take_long    = (state_q == ST_IDLE) && rx_valid && cls.is_long;
    assign take_payload = (state_q == ST_PAYLOAD) && rx_valid;

    hostcmd_payload #(
        .DATA_BYTES (DATA_BYTES),
        .BYTE_W     (8)
    ) u_payload (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (take_long),
        .shift   (take_payload),
        .byte_in (rx_byte),
        .word    (wr_data),
        .last    (pl_last)
    );

    hostcmd_gap_timer #(
        .LIMIT (GAP_CYCLES)
    ) u_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state_q == ST_PAYLOAD),
        .kick   (rx_valid),
        .expire (gap_expire)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: long opcode, fourth byte, stall timeout
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take_long) state_d = ST_PAYLOAD;
            end
            ST_PAYLOAD: begin
                if (take_payload && pl_last) state_d = ST_IDLE;
                else if (gap_expire)         state_d = ST_IDLE;
            end
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_reset <= 1'b0;
            cmd_arm   <= 1'b0;
            cmd_ident <= 1'b0;
            cmd_xon   <= 1'b0;
            cmd_xoff  <= 1'b0;
            wr_en     <= 1'b0;
            op_q      <= 8'h00;
            sel_q     <= SEL_NONE;
            stage_q   <= 2'd0;
        end else begin
            cmd_reset <= 1'b0;
            cmd_arm   <= 1'b0;
            cmd_ident <= 1'b0;
            cmd_xon   <= 1'b0;
            cmd_xoff  <= 1'b0;
            wr_en     <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (rx_valid) begin
                        if (cls.is_long) begin
                            op_q    <= rx_byte;
                            sel_q   <= cls.sel;
                            stage_q <= cls.stage;
                        end else begin
                            cmd_reset <= (cls.act == ACT_RESET);
                            cmd_arm   <= (cls.act == ACT_ARM);
                            cmd_ident <= (cls.act == ACT_IDENT);
                            cmd_xon   <= (cls.act == ACT_XON);
                            cmd_xoff  <= (cls.act == ACT_XOFF);
                        end
                    end
                end
                ST_PAYLOAD: begin
                    if (take_payload && pl_last && (sel_q != SEL_NONE)) begin
                        wr_en <= 1'b1;
                    end
                end
            endcase
        end
    end

    assign wr_opcode = op_q;
    assign wr_sel    = sel_q;
    assign wr_stage  = stage_q;
    assign id_reply  = ID_WORD;
endmodule

// File: rtl/hostcmd_decoder_chk.sv
module hostcmd_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] rx_byte,
    input logic       rx_valid,
    input logic       cmd_reset,
    input logic       cmd_arm,
    input logic       cmd_ident,
    input logic       cmd_xon,
    input logic       cmd_xoff,
    input logic       wr_en,
    input logic [7:0] wr_opcode,
    input logic [2:0] wr_sel,
    input logic [1:0] wr_stage
);
    // R12
    pulse_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_reset, cmd_arm, cmd_ident, cmd_xon, cmd_xoff, wr_en}));

    // R2
    arm_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_arm |-> ($past(rx_valid) && $past(rx_byte) == 8'h01));

    // R2
    reset_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reset |-> ($past(rx_valid) && $past(rx_byte) == 8'h00));

    // R5
    wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R5
    wr_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(rx_valid));

    // R6
    trig_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_opcode[7:4] == 4'hC) |->
            (wr_stage == wr_opcode[3:2] && wr_sel == {1'b0, wr_opcode[1:0]}));

    // R7
    divider_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_opcode == 8'h80) |-> (wr_sel == 3'd3 && wr_stage == 2'd0));
endmodule

bind hostcmd_decoder hostcmd_decoder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_byte   (rx_byte),
    .rx_valid  (rx_valid),
    .cmd_reset (cmd_reset),
    .cmd_arm   (cmd_arm),
    .cmd_ident (cmd_ident),
    .cmd_xon   (cmd_xon),
    .cmd_xoff  (cmd_xoff),
    .wr_en     (wr_en),
    .wr_opcode (wr_opcode),
    .wr_sel    (wr_sel),
    .wr_stage  (wr_stage)
);

// File: tb/hostcmd_decoder_tb.sv
`timescale 1ns/1ps
module hostcmd_decoder_tb;
    localparam int GAP = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        rx_valid = 1'b0;
    logic        cmd_reset, cmd_arm, cmd_ident, cmd_xon, cmd_xoff, wr_en;
    logic [31:0] id_reply, wr_data;
    logic [7:0]  wr_opcode;
    logic [2:0]  wr_sel;
    logic [1:0]  wr_stage;

    always #2.5 clk = ~clk;

    hostcmd_decoder #(.GAP_CYCLES(GAP)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .cmd_reset(cmd_reset), .cmd_arm(cmd_arm), .cmd_ident(cmd_ident),
        .cmd_xon(cmd_xon), .cmd_xoff(cmd_xoff), .id_reply(id_reply),
        .wr_en(wr_en), .wr_opcode(wr_opcode), .wr_sel(wr_sel),
        .wr_stage(wr_stage), .wr_data(wr_data)
    );

    int n_run = 0, n_fail = 0;
    bit done = 0;
    int c_rst = 0, c_arm = 0, c_id = 0, c_xon = 0, c_xoff = 0, c_wr = 0, c_multi = 0;
    logic [7:0]  l_op;
    logic [31:0] l_data;
    logic [2:0]  l_sel;
    logic [1:0]  l_stage;

    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (cmd_reset) c_rst++;
            if (cmd_arm)   c_arm++;
            if (cmd_ident) c_id++;
            if (cmd_xon)   c_xon++;
            if (cmd_xoff)  c_xoff++;
            if (wr_en) begin
                c_wr++; l_op = wr_opcode; l_data = wr_data; l_sel = wr_sel; l_stage = wr_stage;
            end
            if ((32'(cmd_reset) + 32'(cmd_arm) + 32'(cmd_ident) + 32'(cmd_xon)
                 + 32'(cmd_xoff) + 32'(wr_en)) > 1) c_multi++;
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_sel(input logic [7:0] op);
        if (op[7:4] == 4'hC && op[1:0] != 2'b11) return int'(op[1:0]);
        if (op == 8'h80) return 3;
        if (op == 8'h81) return 4;
        if (op == 8'h82) return 5;
        return 7;
    endfunction

    function automatic int exp_stage(input logic [7:0] op);
        if (op[7:4] == 4'hC) return int'(op[3:2]);
        return 0;
    endfunction

    // Called at a falling edge; returns at the next falling edge.
    task automatic send(input logic [7:0] b);
        rx_byte = b; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check_short(input string req, input logic [7:0] b);
        int r0, a0, i0, x0, f0, w0;
        r0 = c_rst; a0 = c_arm; i0 = c_id; x0 = c_xon; f0 = c_xoff; w0 = c_wr;
        send(b); idle(1);
        chk(req, "reset pulses", c_rst - r0, (b == 8'h00) ? 1 : 0);
        chk(req, "arm pulses",   c_arm - a0, (b == 8'h01) ? 1 : 0);
        chk(req, "ident pulses", c_id - i0,  (b == 8'h02) ? 1 : 0);
        chk(req, "xon pulses",   c_xon - x0, (b == 8'h11) ? 1 : 0);
        chk(req, "xoff pulses",  c_xoff - f0,(b == 8'h13) ? 1 : 0);
        chk(req, "writes",       c_wr - w0, 0);
    endtask

    task automatic check_long(input string req, input logic [7:0] op, input logic [31:0] d, input int gapmax);
        int w0, s0;
        w0 = c_wr;
        s0 = c_rst + c_arm + c_id + c_xon + c_xoff;
        send(op);
        for (int k = 0; k < 4; k++) begin
            if (gapmax > 0) idle($urandom_range(gapmax));
            send(d[8*k +: 8]);
        end
        idle(1);
        chk(req, "payload pulses", c_rst + c_arm + c_id + c_xon + c_xoff - s0, 0);
        if (exp_sel(op) == 7) begin
            chk(req, "writes (none)", c_wr - w0, 0);
        end else begin
            chk(req, "writes", c_wr - w0, 1);
            chk(req, "wr_opcode", l_op, op);
            chk(req, "wr_data", l_data, d);
            chk(req, "wr_sel", l_sel, exp_sel(op));
            chk(req, "wr_stage", l_stage, exp_stage(op));
        end
    endtask

    initial begin
        #500000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] shorts[8];
        logic [7:0] longs[12];
        void'($urandom(32'd20240611));
        shorts = '{8'h00, 8'h01, 8'h02, 8'h11, 8'h13, 8'h03, 8'h12, 8'h7F};
        longs  = '{8'hC0, 8'hC5, 8'hCA, 8'hCF, 8'hC1, 8'hC6, 8'hC8, 8'h80, 8'h81, 8'h82, 8'h83, 8'hE4};

        idle(3);
        // R1: reset state
        chk("R1", "outputs in reset", {cmd_reset, cmd_arm, cmd_ident, cmd_xon, cmd_xoff, wr_en}, 0);
        rst_n = 1'b1;
        idle(2);
        chk("R1", "outputs after reset", {cmd_reset, cmd_arm, cmd_ident, cmd_xon, cmd_xoff, wr_en}, 0);

        // R11: reply word and identify request
        chk("R11", "id_reply", id_reply, 32'h31414C53);
        check_short("R11", 8'h02);

        // R2: each short opcode
        check_short("R2", 8'h00);
        check_short("R2", 8'h01);
        check_short("R2", 8'h11);
        check_short("R2", 8'h13);
        // R3: unknown short bytes ignored
        check_short("R3", 8'h03);
        check_short("R3", 8'h10);
        check_short("R3", 8'h12);
        check_short("R3", 8'h7F);

        // R4 R5: payload holding command codes, back-to-back, LSB first
        check_long("R4", 8'hC0, 32'h13_00_02_01, 0);
        check_long("R5", 8'hC1, 32'hDEADBEEF, 0);

        // R6 R8: every trigger opcode
        for (int s = 0; s < 4; s++)
            for (int y = 0; y < 4; y++)
                check_long((y == 3) ? "R8" : "R6", {4'hC, 2'(s), 2'(y)}, $urandom, 2);
        // R7: system registers
        check_long("R7", 8'h80, 32'h0000_0063, 1);
        check_long("R7", 8'h81, 32'h0100_0200, 1);
        check_long("R7", 8'h82, 32'h0000_003C, 1);
        // R8: unknown long opcodes then a fresh command
        check_long("R8", 8'h83, 32'h01010101, 0);
        check_long("R8", 8'hFF, 32'h02020202, 0);
        check_short("R8", 8'h01);

        // R9: stall timeout discards partial command
        begin
            int a0, w0, x0;
            a0 = c_arm; w0 = c_wr; x0 = c_xon;
            send(8'hC5); send(8'hAA); send(8'hBB);
            idle(GAP + 4);
            send(8'h01); send(8'h11); send(8'h22); send(8'h33);
            idle(1);
            chk("R9", "arm after timeout", c_arm - a0, 1);
            chk("R9", "xon after timeout", c_xon - x0, 1);
            chk("R9", "no write after timeout", c_wr - w0, 0);
        end
        // R9: gaps just under the limit keep collecting
        begin
            int w0;
            w0 = c_wr;
            send(8'hC8);
            for (int k = 0; k < 4; k++) begin idle(GAP - 5); send(8'(8'h10 + k)); end
            idle(1);
            chk("R9", "write with long gaps", c_wr - w0, 1);
            chk("R9", "data with long gaps", l_data, 32'h13121110);
        end

        // R10: five resets from each parser position
        for (int p = 0; p <= 4; p++) begin
            int r0, a0;
            if (p > 0) begin
                send(8'hC2);
                for (int k = 0; k < 4 - p; k++) send(8'h5A);
            end
            r0 = c_rst;
            for (int k = 0; k < 5; k++) send(8'h00);
            idle(1);
            chk("R10", $sformatf("reset pulses, %0d pending", p), c_rst - r0, 5 - p);
            a0 = c_arm;
            send(8'h01); idle(1);
            chk("R10", "idle after resets", c_arm - a0, 1);
        end

        // Random mix
        for (int it = 0; it < 250; it++) begin
            if ($urandom_range(1) == 0) begin
                logic [7:0] b;
                b = ($urandom_range(3) == 0) ? 8'($urandom_range(127)) : shorts[$urandom_range(7)];
                check_short("R2", b);
            end else begin
                logic [7:0] op;
                op = ($urandom_range(4) == 0) ? (8'($urandom) | 8'h80) : longs[$urandom_range(11)];
                check_long("R5", op, $urandom, 3);
            end
        end

        // R12: no cycle with two results
        chk("R12", "multi-pulse cycles", c_multi, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule